// File: doc/BRIEF.md
# Chip Reset Sequencer

This block decides when the rest of a chip may leave reset. It watches five sources of reset: power-on, a board-level reset pin (active low), a clock-loss flag, the PLL lock flag and an on-chip reset request. When any of them fires, it asserts a reset output and keeps it asserted through a fixed recovery sequence. It first waits for PLL lock. It then counts a settling interval of 512 clocks, samples a configuration pin group on the last reset cycle, and only then releases the output. Each cause that starts or diverts a sequence sets a sticky bit in a cause register. Only a new power-on clears that register.

The sequence reacts to new events while it runs. If lock drops during the count, the sequence goes back to waiting for lock and the count starts again. A power-on event restarts everything at once. If the reset pin stays low for four clock edges, the sequence moves to waiting for the pin to go high again. The pin request and the on-chip request from the running state both wait for the current bus cycle to end before reset is asserted. A clock or lock failure during that wait ends the wait early. The power-on flag is the asynchronous reset of every register. The pin and both monitor flags pass through two-stage synchronisers before the controller uses them.

Top module: `reset_sequencer`

## Requirements
- R1: While porIn is high, rstOut is 1, cfgOut is 0 and status is 5'b00001. Status bit 0 means power-on, bit 1 the reset pin, bit 2 clock loss, bit 3 lock loss and bit 4 the on-chip request.
- R2: After porIn falls with lockIn high and clkLoss low, rstOut stays 1 for 515 clock edges and is 0 after the 516th edge. That count is 2 synchroniser stages, 1 lock-detect cycle, 512 settling cycles and 1 capture cycle.
- R3: cfgOut takes the cfgPin level present on the last reset cycle and then holds it. Changes of cfgPin while rstOut is 0 do not change cfgOut.
- R4: If lockIn falls while running, rstOut is 1 after the third edge and status bit 3 is set. rstOut falls 516 edges after lockIn rises again.
- R5: If clkLoss rises while running, rstOut is 1 after the third edge and status bit 2 is set. rstOut falls 516 edges after clkLoss clears.
- R6: If lock is lost during the settling count, the count starts again from zero. rstOut falls 516 edges after lockIn returns high.
- R7: During the lock wait or the settling count, a reset-pin low lasting three edges is ignored: no status bit 1 and no change to the release time. A low lasting four or more edges is recognised: bit 1 is set, rstOut stays 1, and rstOut falls 517 edges after the pin returns high.
- R8: An intReq pulse while running keeps rstOut at 0 until busDone is seen. rstOut is 1 on the edge that samples busDone high, status bit 4 is set, and rstOut falls 515 edges after busDone was raised.
- R9: A recognised pin request while running also waits for busDone, with rstOut at 0. A lock loss during that wait ends it: rstOut is 1 three edges after lockIn falls, bit 1 is set, and the controller waits for the pin to return high.
- R10: Raising porIn in the middle of a sequence restarts it. status returns to 5'b00001, cfgOut to 0, and release timing follows R2.
- R11: Priority in one cycle is power-on, then the reset pin, then clock or lock loss, then the on-chip request. A lock loss seen in the same cycle as intReq asserts rstOut without waiting for busDone, and sets bit 3 but not bit 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| porIn | input | 1 | Power-on flag, active high; asynchronous reset of every register |
| extRstN | input | 1 | Board reset pin, active low, asynchronous |
| clkLoss | input | 1 | Clock-monitor failure flag, asynchronous |
| lockIn | input | 1 | PLL lock flag, asynchronous |
| intReq | input | 1 | On-chip reset request, synchronous |
| busDone | input | 1 | Current bus cycle has completed, synchronous |
| cfgPin | input | CFG_W | Configuration pin levels |
| rstOut | output | 1 | Chip reset, active high |
| cfgOut | output | CFG_W | Configuration captured at reset release |
| status | output | 5 | Sticky reset-cause bits |

## Verification
The hardest case to reach is a second event that lands inside one 512-cycle count. Examples are a lock drop at an arbitrary count value, or a pin pulse one edge shorter than the qualification length. From the ports, each of these needs exact edge counting through the synchronisers. The stimulus uses a fixed-seed random offset into the count and a random outage length, and it drives directed pulses of exactly three and ten edges. Every release edge is predicted by a bench function from the synchroniser depth, the settling length and the capture cycle. The termination of a bus wait by a lock loss is reached by qualifying the pin while running and holding busDone low.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

  localparam int CAUSE_N    = 5;
  localparam int CAUSE_POR  = 0;
  localparam int CAUSE_EXT  = 1;
  localparam int CAUSE_CLK  = 2;
  localparam int CAUSE_LOCK = 3;
  localparam int CAUSE_INT  = 4;

  typedef enum logic [2:0] {
    ST_RUN,
    ST_BUS,
    ST_LOCK,
    ST_SETTLE,
    ST_LATCH,
    ST_EXT
  } seqState_t;

  typedef struct packed {
    logic               clrSettle;
    logic               incSettle;
    logic               latchCfg;
    logic [CAUSE_N-1:0] setCause;
  } seqStrobe_t;

endpackage

// File: rtl/rst_seq_dp.sv
module rst_seq_dp
  import rst_seq_pkg::*;
#(
  parameter int SETTLE_CYCLES = 512,
  parameter int EXT_QUAL      = 4,
  parameter int SYNC_STAGES   = 2,
  parameter int CFG_W         = 2,
  localparam int CW           = $clog2(SETTLE_CYCLES + 1),
  localparam int QW           = $clog2(EXT_QUAL + 1)
) (
  input  logic               clk,
  input  logic               porIn,
  input  logic               extRstN,
  input  logic               clkLoss,
  input  logic               lockIn,
  input  logic [CFG_W-1:0]   cfgPin,
  input  seqStrobe_t         stb,
  output logic               extQual,
  output logic               extHigh,
  output logic               clkLossS,
  output logic               lockS,
  output logic               settleDone,
  output logic [CW-1:0]      settleCnt,
  output logic [CFG_W-1:0]   cfgOut,
  output logic [CAUSE_N-1:0] status
);

  localparam logic [CW-1:0]      SETTLE_LAST = CW'(SETTLE_CYCLES - 1);
  localparam logic [QW-1:0]      QUAL_MAX    = QW'(EXT_QUAL);
  localparam logic [CAUSE_N-1:0] STAT_PWRUP  = CAUSE_N'(1) << CAUSE_POR;

  logic [SYNC_STAGES-1:0] extPipe, clkPipe, lockPipe;
  logic [QW-1:0]          qualCnt;

  // two-or-more stage synchronisers for the asynchronous inputs
  always_ff @(posedge clk or posedge porIn) begin
    if (porIn) begin
      extPipe  <= '1;
      clkPipe  <= '0;
      lockPipe <= '0;
    end else begin
      extPipe  <= {extPipe[SYNC_STAGES-2:0], extRstN};
      clkPipe  <= {clkPipe[SYNC_STAGES-2:0], clkLoss};
      lockPipe <= {lockPipe[SYNC_STAGES-2:0], lockIn};
    end
  end

  assign extHigh  = extPipe[SYNC_STAGES-1];
  assign clkLossS = clkPipe[SYNC_STAGES-1];
  assign lockS    = lockPipe[SYNC_STAGES-1];

  // saturating pin-low qualifier, cleared whenever the pin reads high
  always_ff @(posedge clk or posedge porIn) begin
    if (porIn)                  qualCnt <= '0;
    else if (extHigh)           qualCnt <= '0;
    else if (qualCnt != QUAL_MAX) qualCnt <= qualCnt + 1'b1;
  end

  assign extQual = (qualCnt == QUAL_MAX);

  always_ff @(posedge clk or posedge porIn) begin
    if (porIn)              settleCnt <= '0;
    else if (stb.clrSettle) settleCnt <= '0;
    else if (stb.incSettle) settleCnt <= settleCnt + 1'b1;
  end

  assign settleDone = (settleCnt == SETTLE_LAST);

  always_ff @(posedge clk or posedge porIn) begin
    if (porIn) begin
      cfgOut <= '0;
      status <= STAT_PWRUP;
    end else begin
      if (stb.latchCfg) cfgOut <= cfgPin;
      status <= status | stb.setCause;
    end
  end

endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
  import rst_seq_pkg::*;
(
  input  logic       clk,
  input  logic       porIn,
  input  logic       intReq,
  input  logic       busDone,
  input  logic       extQual,
  input  logic       extHigh,
  input  logic       clkLossS,
  input  logic       lockS,
  input  logic       settleDone,
  output seqStrobe_t stb,
  output seqState_t  seqState,
  output logic       rstOut
);

  seqState_t stateNxt;
  logic      pendExt, pendExtNxt;
  logic      lossNow;
  logic [CAUSE_N-1:0] lossBits;

  always_ff @(posedge clk or posedge porIn) begin
    if (porIn) begin
      seqState <= ST_LOCK;
      pendExt  <= 1'b0;
    end else begin
      seqState <= stateNxt;
      pendExt  <= pendExtNxt;
    end
  end

  always_comb begin
    lossNow = clkLossS || !lockS;
    lossBits = '0;
    lossBits[CAUSE_CLK]  = clkLossS;
    lossBits[CAUSE_LOCK] = !lockS;
  end

  always_comb begin
    stb        = '0;
    stateNxt   = seqState;
    pendExtNxt = pendExt;
    unique case (seqState)
      ST_RUN: begin
        if (extQual) begin
          stateNxt   = ST_BUS;
          pendExtNxt = 1'b1;
        end else if (lossNow) begin
          stb.setCause  = lossBits;
          stb.clrSettle = 1'b1;
          stateNxt      = ST_LOCK;
        end else if (intReq) begin
          stateNxt   = ST_BUS;
          pendExtNxt = 1'b0;
        end
      end
      ST_BUS: begin
        if (busDone || lossNow) begin
          stb.setCause[pendExt ? CAUSE_EXT : CAUSE_INT] = 1'b1;
          stb.clrSettle = 1'b1;
          stateNxt      = pendExt ? ST_EXT : ST_LOCK;
        end
      end
      ST_LOCK: begin
        stb.clrSettle = 1'b1;
        if (extQual) begin
          stb.setCause[CAUSE_EXT] = 1'b1;
          stateNxt = ST_EXT;
        end else if (!lossNow) begin
          stateNxt = ST_SETTLE;
        end
      end
      ST_SETTLE: begin
        stb.incSettle = 1'b1;
        if (extQual) begin
          stb.setCause[CAUSE_EXT] = 1'b1;
          stateNxt = ST_EXT;
        end else if (lossNow) begin
          stb.clrSettle = 1'b1;
          stateNxt      = ST_LOCK;
        end else if (settleDone) begin
          stateNxt = ST_LATCH;
        end
      end
      ST_LATCH: begin
        stb.latchCfg = 1'b1;
        stateNxt     = ST_RUN;
      end
      ST_EXT: begin
        if (extHigh) begin
          stb.clrSettle = 1'b1;
          stateNxt      = ST_LOCK;
        end
      end
      default: stateNxt = ST_LOCK;
    endcase
  end

  assign rstOut = !(seqState == ST_RUN || seqState == ST_BUS);

endmodule

// File: rtl/reset_sequencer.sv
module reset_sequencer
  import rst_seq_pkg::*;
#(
  parameter int SETTLE_CYCLES = 512,
  parameter int EXT_QUAL      = 4,
  parameter int SYNC_STAGES   = 2,
  parameter int CFG_W         = 2,
  localparam int CW           = $clog2(SETTLE_CYCLES + 1)
) (
  input  logic               clk,
  input  logic               porIn,
  input  logic               extRstN,
  input  logic               clkLoss,
  input  logic               lockIn,
  input  logic               intReq,
  input  logic               busDone,
  input  logic [CFG_W-1:0]   cfgPin,
  output logic               rstOut,
  output logic [CFG_W-1:0]   cfgOut,
  output logic [CAUSE_N-1:0] status
);

  seqStrobe_t    stb;
  seqState_t     seqState;
  logic          extQual, extHigh, clkLossS, lockS, settleDone;
  logic [CW-1:0] settleCnt;

  rst_seq_dp #(
    .SETTLE_CYCLES(SETTLE_CYCLES),
    .EXT_QUAL     (EXT_QUAL),
    .SYNC_STAGES  (SYNC_STAGES),
    .CFG_W        (CFG_W)
  ) u_dp (
    .clk       (clk),
    .porIn     (porIn),
    .extRstN   (extRstN),
    .clkLoss   (clkLoss),
    .lockIn    (lockIn),
    .cfgPin    (cfgPin),
    .stb       (stb),
    .extQual   (extQual),
    .extHigh   (extHigh),
    .clkLossS  (clkLossS),
    .lockS     (lockS),
    .settleDone(settleDone),
    .settleCnt (settleCnt),
    .cfgOut    (cfgOut),
    .status    (status)
  );

  rst_seq_ctrl u_ctrl (
    .clk       (clk),
    .porIn     (porIn),
    .intReq    (intReq),
    .busDone   (busDone),
    .extQual   (extQual),
    .extHigh   (extHigh),
    .clkLossS  (clkLossS),
    .lockS     (lockS),
    .settleDone(settleDone),
    .stb       (stb),
    .seqState  (seqState),
    .rstOut    (rstOut)
  );

endmodule

// File: rtl/reset_sequencer_chk.sv
module reset_sequencer_chk
  import rst_seq_pkg::*;
#(
  parameter int SETTLE_CYCLES = 512,
  parameter int CFG_W         = 2,
  localparam int CW           = $clog2(SETTLE_CYCLES + 1)
) (
  input logic               clk,
  input logic               porIn,
  input logic               busDone,
  input logic               rstOut,
  input logic [CFG_W-1:0]   cfgOut,
  input logic [CAUSE_N-1:0] status,
  input seqState_t          seqState,
  input logic               extQual,
  input logic               clkLossS,
  input logic               lockS,
  input logic [CW-1:0]      settleCnt
);

  // R1
  status_sticky_chk: assert property (@(posedge clk) disable iff (porIn)
    ((status & $past(status)) == $past(status)));

  // R3
  cfg_on_release_chk: assert property (@(posedge clk) disable iff (porIn)
    !$stable(cfgOut) |-> $fell(rstOut));

  // R6
  settle_bound_chk: assert property (@(posedge clk) disable iff (porIn)
    settleCnt <= CW'(SETTLE_CYCLES));

  // R4
  loss_asserts_rst_chk: assert property (@(posedge clk) disable iff (porIn)
    (seqState == ST_RUN && !extQual && (clkLossS || !lockS)) |=> rstOut);

  // R7
  ext_holds_rst_chk: assert property (@(posedge clk) disable iff (porIn)
    (rstOut && extQual && seqState != ST_LATCH) |=> rstOut);

  // R8
  bus_wait_low_chk: assert property (@(posedge clk) disable iff (porIn)
    (seqState == ST_BUS && !busDone && lockS && !clkLossS) |=> !rstOut);

endmodule

bind reset_sequencer reset_sequencer_chk #(
  .SETTLE_CYCLES(SETTLE_CYCLES),
  .CFG_W        (CFG_W)
) u_chk (
  .clk      (clk),
  .porIn    (porIn),
  .busDone  (busDone),
  .rstOut   (rstOut),
  .cfgOut   (cfgOut),
  .status   (status),
  .seqState (seqState),
  .extQual  (extQual),
  .clkLossS (clkLossS),
  .lockS    (lockS),
  .settleCnt(settleCnt)
);

// File: tb/reset_sequencer_bench.sv
module reset_sequencer_bench;

  localparam int SETTLE = 512;
  localparam int SYNC   = 2;
  localparam int CFG_W  = 2;

  logic             clk = 1'b0;
  logic             porIn, extRstN, clkLoss, lockIn, intReq, busDone;
  logic [CFG_W-1:0] cfgPin;
  logic             rstOut;
  logic [CFG_W-1:0] cfgOut;
  logic [4:0]       status;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  int expStat;
  int expCfg;

  always #10 clk = ~clk;

  reset_sequencer #(.SETTLE_CYCLES(SETTLE), .SYNC_STAGES(SYNC), .CFG_W(CFG_W))
    u_reset_sequencer (
      .clk(clk), .porIn(porIn), .extRstN(extRstN), .clkLoss(clkLoss),
      .lockIn(lockIn), .intReq(intReq), .busDone(busDone), .cfgPin(cfgPin),
      .rstOut(rstOut), .cfgOut(cfgOut), .status(status));

  // edges from a monitor flag becoming good to reset release
  function automatic int relFromGood();
    return SYNC + 1 + SETTLE + 1;
  endfunction

  // edges from the pin returning high to reset release
  function automatic int relFromPin();
    return SYNC + 1 + 1 + SETTLE + 1;
  endfunction

  // edges from busDone raised to reset release
  function automatic int relFromBus();
    return 1 + 1 + SETTLE + 1;
  endfunction

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic expectRelease(input string req, input int edges);
    step(edges - 1);
    chk(req, int'(rstOut), 1);
    step(1);
    chk(req, int'(rstOut), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    porIn = 1'b1; extRstN = 1'b1; clkLoss = 1'b0; lockIn = 1'b1;
    intReq = 1'b0; busDone = 1'b0; cfgPin = 2'd2;
    step(3);
    // R1 reset state
    chk("R1 rstOut", int'(rstOut), 1);
    chk("R1 status", int'(status), 1);
    chk("R1 cfgOut", int'(cfgOut), 0);
    expStat = 1;

    // R2 release timing after power-on
    porIn = 1'b0;
    expectRelease("R2 power-on release", relFromGood());
    chk("R3 cfg captured", int'(cfgOut), 2);
    expCfg = 2;
    cfgPin = 2'd1;
    step(5);
    chk("R3 cfg ignored while running", int'(cfgOut), expCfg);

    // R4 lock loss while running
    lockIn = 1'b0;
    step(SYNC);
    chk("R4 still running", int'(rstOut), 0);
    step(1);
    chk("R4 reset asserted", int'(rstOut), 1);
    expStat |= 8;
    chk("R4 status", int'(status), expStat);
    step(20);
    chk("R4 held without lock", int'(rstOut), 1);
    cfgPin = 2'd3;
    lockIn = 1'b1;
    expectRelease("R4 release", relFromGood());
    chk("R3 new cfg", int'(cfgOut), 3);

    // R5 clock loss while running
    clkLoss = 1'b1;
    step(SYNC + 1);
    chk("R5 reset asserted", int'(rstOut), 1);
    expStat |= 4;
    chk("R5 status", int'(status), expStat);
    step(7);
    clkLoss = 1'b0;
    // R7 short pin pulse during settling is ignored
    step(100);
    extRstN = 1'b0;
    step(3);
    extRstN = 1'b1;
    step(relFromGood() - 104);
    chk("R7 short pulse ignored", int'(rstOut), 1);
    step(1);
    chk("R7 short pulse timing", int'(rstOut), 0);
    chk("R7 short pulse status", int'(status), expStat);

    // R7 long pin pulse during settling is recognised
    lockIn = 1'b0;
    step(4);
    lockIn = 1'b1;
    step(50);
    extRstN = 1'b0;
    step(10);
    chk("R7 held in reset", int'(rstOut), 1);
    expStat |= 2;
    chk("R7 status", int'(status), expStat);
    extRstN = 1'b1;
    expectRelease("R7 release after pin", relFromPin());

    // R8 on-chip request waits for bus cycle
    intReq = 1'b1;
    step(1);
    intReq = 1'b0;
    step(5);
    chk("R8 waits for bus", int'(rstOut), 0);
    busDone = 1'b1;
    step(1);
    busDone = 1'b0;
    chk("R8 reset asserted", int'(rstOut), 1);
    expStat |= 16;
    chk("R8 status", int'(status), expStat);
    expectRelease("R8 release", relFromBus() - 1);

    // R10 power-on mid-sequence
    lockIn = 1'b0;
    step(4);
    lockIn = 1'b1;
    step(100);
    porIn = 1'b1;
    step(2);
    chk("R10 status", int'(status), 1);
    chk("R10 cfgOut", int'(cfgOut), 0);
    chk("R10 rstOut", int'(rstOut), 1);
    expStat = 1;
    cfgPin = 2'd1;
    porIn = 1'b0;
    expectRelease("R10 release", relFromGood());
    chk("R10 cfg", int'(cfgOut), 1);

    // R11 lock loss beats on-chip request in the same cycle
    lockIn = 1'b0;
    step(SYNC);
    intReq = 1'b1;
    step(1);
    intReq = 1'b0;
    chk("R11 reset without bus wait", int'(rstOut), 1);
    expStat |= 8;
    chk("R11 status", int'(status), expStat);
    lockIn = 1'b1;
    expectRelease("R11 release", relFromGood());

    // R9 loss during bus wait of a pin request
    extRstN = 1'b0;
    step(8);
    chk("R9 bus wait", int'(rstOut), 0);
    lockIn = 1'b0;
    step(SYNC + 1);
    chk("R9 terminated", int'(rstOut), 1);
    expStat |= 2;
    chk("R9 status", int'(status), expStat);
    lockIn = 1'b1;
    step(10);
    chk("R9 waits for pin", int'(rstOut), 1);
    extRstN = 1'b1;
    expectRelease("R9 release", relFromPin());

    // R6 random lock drops inside the settling count
    for (int i = 0; i < 4; i++) begin
      int drop, gap, cfg;
      cfg  = int'($urandom % 4);
      drop = 20 + int'($urandom % 400);
      gap  = 1 + int'($urandom % 20);
      lockIn = 1'b0;
      step(3);
      lockIn = 1'b1;
      step(drop);
      lockIn = 1'b0;
      step(gap);
      cfgPin = CFG_W'(cfg);
      lockIn = 1'b1;
      expectRelease("R6 restart after lock drop", relFromGood());
      chk("R3 random cfg", int'(cfgOut), cfg);
    end
    chk("R6 status", int'(status), expStat);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule